// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block forms the radix-2 Montgomery product of two operands modulo an odd modulus. Given A, B and N of width W bits, it returns A·B·2^-W mod N. It works one bit of B per clock and uses only additions, a two-way selection and a one-bit right shift. It never divides. Each step adds A when the current bit of B is set. If the running sum is then odd, the step adds N. The sum is then even, so the halving that follows is exact.

A caller waits for `ready`, then presents the three operands with a one-cycle `start`. The unit copies them into its own registers and runs W iterations, least significant bit of B first. In one further cycle it resolves the redundant accumulator and brings the value into the range [0, N-1]. The result appears on `m_out`, marked by a one-cycle `m_valid` pulse. A parameter selects how the accumulator is held: as a carry-save pair of vectors (the default), or as a single carry-propagated value.

Top module: `mont_mul_serial`

## Requirements
- R1: While reset is asserted, and after it is released until the first `start` is accepted, `ready` is 1, `m_valid` is 0 and `m_out` is 0.
- R2: For odd N and A, B < N, the value on `m_out` during the `m_valid` cycle equals A·B·2^-W mod N, using the operands captured when `start` was accepted.
- R3: `m_valid` is high for exactly one cycle. That cycle comes W+1 clock edges after the edge that accepted `start`.
- R4: `ready` is 0 from the cycle after an accepted `start` up to the result. It is 1 again in the same cycle as `m_valid`. A `start` is accepted only on an edge where `ready` is 1.
- R5: A `start` that arrives while `ready` is 0 is ignored. It does not change the pending result or its timing.
- R6: After acceptance, changes on `a_in`, `b_in` and `n_in` have no effect on the operation in progress.
- R7: `m_out` keeps its value from one `m_valid` pulse until the next.
- R8: The delivered result is always strictly less than the captured N.
- R9: With W = 128, A = 7, B = 4 and N = 15, the result is 13.
- R10: A `start` given in the `m_valid` cycle begins a new operation at once, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a multiplication; taken only while `ready` is 1 |
| a_in | input | W | Multiplicand A |
| b_in | input | W | Multiplier B; its bits are scanned from bit 0 upward |
| n_in | input | W | Odd modulus N |
| ready | output | 1 | Unit is idle and able to accept `start` |
| m_out | output | W | Montgomery product, held until the next result |
| m_valid | output | 1 | One-cycle marker of a new result on `m_out` |

## Verification
The properties assume that N is odd and that A and B are below N whenever `start` is accepted. The range property on the result, in particular, means nothing when a caller breaks this assumption. The stimulus always forces bit 0 of the modulus to 1 and reduces every random operand modulo that modulus before it is presented. The edge operands (zero, N-1, N = 1 and N = 3) are chosen inside the same limits. The bench deliberately drives `start` pulses and operand changes while the unit is busy. No assumption constrains these, because the design must tolerate them.

// File: rtl/mont_pkg.sv
package mont_pkg;

   // Sequencer phases: idle, one multiplier bit per cycle, final resolve.
   typedef enum logic [1:0] {
      MM_IDLE = 2'd0,
      MM_RUN  = 2'd1,
      MM_FIN  = 2'd2
   } mm_state_e;

   // Extra accumulator bits over the operand width: the value reached
   // inside one iteration stays below 4N, so two bits are enough.
   localparam int unsigned MM_GUARD = 2;

endpackage

// File: rtl/mm_csa.sv
// 3:2 compressor: turns three vectors into a sum vector and a carry vector
// whose total equals the total of the inputs (modulo 2^L).
module mm_csa #(
   parameter int unsigned L = 130
) (
   input  logic [L-1:0] x,
   input  logic [L-1:0] y,
   input  logic [L-1:0] z,
   output logic [L-1:0] sum,
   output logic [L-1:0] carry
);

   logic [L-1:0] maj;

   always_comb begin
      sum   = x ^ y ^ z;
      maj   = (x & y) | (x & z) | (y & z);
      carry = maj << 1;
   end

endmodule

// File: rtl/mm_step.sv
// One Montgomery iteration: add A if the scanned bit is set, add N when
// the partial total is odd, then halve exactly.
module mm_step #(
   parameter int unsigned W       = 128,
   parameter int unsigned L       = 130,
   parameter bit          USE_CSA = 1'b1
) (
   input  logic [L-1:0] s_in,
   input  logic [L-1:0] c_in,
   input  logic [W-1:0] a_op,
   input  logic [W-1:0] n_op,
   input  logic         b_bit,
   output logic [L-1:0] s_out,
   output logic [L-1:0] c_out
);

   localparam int unsigned PAD = L - W;

   logic [L-1:0] a_sel;
   logic [L-1:0] n_sel;
   logic         odd;

   // Selection of the multiplicand term.
   assign a_sel = b_bit ? {{PAD{1'b0}}, a_op} : '0;

   generate
      if (USE_CSA) begin : g_csa
         logic [L-1:0] s1, c1, s2, c2;

         mm_csa #(.L(L)) u_add_a (
            .x(s_in), .y(c_in), .z(a_sel), .sum(s1), .carry(c1)
         );

         assign odd   = s1[0] ^ c1[0];
         // Two-way choice between zero and the modulus.
         assign n_sel = odd ? {{PAD{1'b0}}, n_op} : '0;

         mm_csa #(.L(L)) u_add_n (
            .x(s1), .y(c1), .z(n_sel), .sum(s2), .carry(c2)
         );

         // Both vectors are even after the second add, so halving each
         // halves their total with no loss.
         assign s_out = s2 >> 1;
         assign c_out = c2 >> 1;
      end else begin : g_cpa
         logic [L-1:0] t1, t2;

         assign t1    = s_in + c_in + a_sel;
         assign odd   = t1[0];
         assign n_sel = odd ? {{PAD{1'b0}}, n_op} : '0;
         assign t2    = t1 + n_sel;
         assign s_out = t2 >> 1;
         assign c_out = '0;
      end
   endgenerate

endmodule

// File: rtl/mm_reduce.sv
// Merges the redundant accumulator and subtracts N once if needed.
module mm_reduce #(
   parameter int unsigned W = 128,
   parameter int unsigned L = 130
) (
   input  logic [L-1:0] s_in,
   input  logic [L-1:0] c_in,
   input  logic [W-1:0] n_op,
   output logic [W-1:0] r_out
);

   localparam int unsigned PAD = L - W;

   logic [L-1:0] total;
   logic [W-1:0] diff;
   logic         ge_n;

   always_comb begin
      total = s_in + c_in;
      ge_n  = total >= {{PAD{1'b0}}, n_op};
      // The total is below 2N, so the low W bits carry the difference.
      diff  = total[W-1:0] - n_op;
      r_out = ge_n ? diff : total[W-1:0];
   end

endmodule

// File: rtl/mm_ctrl.sv
// Sequencer: accepts a start when idle, counts W iterations, then one
// resolve cycle.
module mm_ctrl
   import mont_pkg::*;
#(
   parameter int unsigned W = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic step_en,
   output logic fin,
   output logic ready
);

   localparam int unsigned CW   = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   mm_state_e    state;
   logic [CW-1:0] cnt;

   assign ready   = (state == MM_IDLE);
   assign accept  = ready && start;
   assign step_en = (state == MM_RUN);
   assign fin     = (state == MM_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= MM_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            MM_IDLE: begin
               if (start) begin
                  state <= MM_RUN;
                  cnt   <= '0;
               end
            end
            MM_RUN: begin
               if (cnt == LAST) begin
                  state <= MM_FIN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            MM_FIN:  state <= MM_IDLE;
            default: state <= MM_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mont_mul_serial.sv
module mont_mul_serial
   import mont_pkg::*;
#(
   parameter int unsigned W       = 128,
   parameter bit          USE_CSA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic [W-1:0] n_in,
   output logic         ready,
   output logic [W-1:0] m_out,
   output logic         m_valid
);

   localparam int unsigned L = W + MM_GUARD;

   generate
      if (W < 2) begin : g_bad_width
         $error("mont_mul_serial: W must be at least 2");
      end
   endgenerate

   logic         accept, step_en, fin;
   logic [W-1:0] a_q, b_q, n_q;
   logic [L-1:0] s_q, c_q;
   logic [L-1:0] s_nx, c_nx;
   logic [W-1:0] red;
   logic [W-1:0] m_q;
   logic         v_q;

   mm_ctrl #(.W(W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .accept  (accept),
      .step_en (step_en),
      .fin     (fin),
      .ready   (ready)
   );

   mm_step #(.W(W), .L(L), .USE_CSA(USE_CSA)) u_step (
      .s_in  (s_q),
      .c_in  (c_q),
      .a_op  (a_q),
      .n_op  (n_q),
      .b_bit (b_q[0]),
      .s_out (s_nx),
      .c_out (c_nx)
   );

   mm_reduce #(.W(W), .L(L)) u_reduce (
      .s_in  (s_q),
      .c_in  (c_q),
      .n_op  (n_q),
      .r_out (red)
   );

   // Operand capture and the multiplier shift register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         n_q <= '0;
      end else if (accept) begin
         a_q <= a_in;
         b_q <= b_in;
         n_q <= n_in;
      end else if (step_en) begin
         b_q <= b_q >> 1;
      end
   end

   // Accumulator pair.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= '0;
         c_q <= '0;
      end else if (accept) begin
         s_q <= '0;
         c_q <= '0;
      end else if (step_en) begin
         s_q <= s_nx;
         c_q <= c_nx;
      end
   end

   // Result register and its marker.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         v_q <= 1'b0;
      end else begin
         v_q <= fin;
         if (fin) begin
            m_q <= red;
         end
      end
   end

   assign m_out   = m_q;
   assign m_valid = v_q;

endmodule

// File: rtl/mont_mul_serial_chk.sv
module mont_mul_serial_chk #(
   parameter int unsigned W = 128
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         ready,
   input logic         m_valid,
   input logic [W-1:0] m_out,
   input logic [W-1:0] n_lat
);

   // Edges since the last accepted start.
   logic [31:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
      end else if (start && ready) begin
         since <= '0;
      end else if (!ready) begin
         since <= since + 1'b1;
      end
   end

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |=> !m_valid);

   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (since == 32'(W + 1)));

   a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (since <= 32'(W)));

   a_r4_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> ready);

   a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);

   a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> $stable(m_out));

   a_r8_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_out < n_lat));

endmodule

bind mont_mul_serial mont_mul_serial_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .ready   (ready),
   .m_valid (m_valid),
   .m_out   (m_out),
   .n_lat   (n_q)
);

// File: tb/tb_mont_mul_serial.sv
module tb_mont_mul_serial;

   localparam int unsigned W      = 128;
   localparam time         CLK_T  = 10ns;
   localparam int          WD_MAX = 200000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0, n_in = '1;
   logic         ready, m_valid;
   logic [W-1:0] m_out;

   int errs = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 1'b0;
   string tag = "R2";

   mont_mul_serial #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_in(a_in), .b_in(b_in), .n_in(n_in),
      .ready(ready), .m_out(m_out), .m_valid(m_valid)
   );

   always #(CLK_T/2) clk = ~clk;

   // Mathematical reference: A*B mod N, then W exact halvings modulo N.
   function automatic logic [W-1:0] ref_mm(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [W-1:0] n);
      logic [2*W-1:0] p;
      p = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) % {{W{1'b0}}, n};
      for (int i = 0; i < W; i++) begin
         if (p[0]) p = (p + {{W{1'b0}}, n}) >> 1;
         else      p = p >> 1;
      end
      return p[W-1:0];
   endfunction

   // Cycle model of the interface.
   int           rem = 0;
   logic [W-1:0] pend_m = '0, pend_n = '1, exp_m = '0, exp_n = '1;
   logic         exp_v = 1'b0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         rem <= 0; exp_m <= '0; exp_v <= 1'b0;
      end else begin
         exp_v <= 1'b0;
         if (rem == 0 && start) begin
            rem    <= W + 1;
            pend_m <= ref_mm(a_in, b_in, n_in);
            pend_n <= n_in;
         end else if (rem > 0) begin
            rem <= rem - 1;
            if (rem == 1) begin
               exp_m <= pend_m; exp_n <= pend_n; exp_v <= 1'b1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Compared on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(ready === (rem == 0), "R4", "ready", W'(ready), W'(rem == 0));
         check(m_valid === exp_v, "R3", "m_valid", W'(m_valid), W'(exp_v));
         check(m_out === exp_m, exp_v ? tag : "R7", "m_out", m_out, exp_m);
         if (exp_v) check(m_out < exp_n, "R8", "below N", m_out, exp_n);
      end
   end

   task automatic op(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [W-1:0] n, input string t);
      @(negedge clk);
      while (rem != 0) @(negedge clk);
      tag = t;
      a_in = a; b_in = b; n_in = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (W + 2) @(negedge clk);
   endtask

   function automatic logic [W-1:0] rnd();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      logic [W-1:0] n, a, b;
      repeat (3) @(negedge clk);
      // R1: values held in reset
      check(ready === 1'b1, "R1", "ready in reset", W'(ready), W'(1));
      check(m_valid === 1'b0, "R1", "valid in reset", W'(m_valid), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(m_out === '0, "R1", "m_out after reset", m_out, '0);
      check(ready === 1'b1, "R1", "ready after reset", W'(ready), W'(1));

      // R9: known vector
      op(W'(7), W'(4), W'(15), "R9");
      check(m_out === W'(13), "R9", "7*4 vector", m_out, W'(13));

      // R2: boundary operands
      op('0, W'(5), W'(11), "R2");
      op(W'(9), '0, W'(11), "R2");
      op('0, '0, W'(1), "R2");
      op(W'(2), W'(2), W'(3), "R2");
      n = rnd() | {1'b1, {(W-2){1'b0}}, 1'b1};
      op(n - 1, n - 1, n, "R2");
      op('1 - 1, '1 - 1, '1, "R2");

      // R2: random operands
      for (int k = 0; k < 8; k++) begin
         n = rnd() | W'(1);
         op(rnd() % n, rnd() % n, n, "R2");
      end

      // R5 and R6: start pulses and operand changes while busy
      n = rnd() | W'(1);
      a = rnd() % n; b = rnd() % n;
      @(negedge clk);
      tag = "R6";
      a_in = a; b_in = b; n_in = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      a_in = rnd(); b_in = rnd(); n_in = rnd() | W'(1);
      repeat (10) @(negedge clk);
      tag = "R5";
      start = 1'b1;
      repeat (5) @(negedge clk);
      start = 1'b0;
      check(ready === 1'b0, "R5", "still busy", W'(ready), W'(0));
      while (!exp_v) @(negedge clk);

      // R10: start in the result cycle, back to back
      n = rnd() | W'(1);
      a = rnd() % n; b = rnd() % n;
      tag = "R10";
      a_in = a; b_in = b; n_in = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(ready === 1'b0, "R10", "accepted in result cycle", W'(ready), W'(0));
      repeat (W + 2) @(negedge clk);
      check(m_out === ref_mm(a, b, n), "R10", "chained result", m_out, ref_mm(a, b, n));
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      wait (cycles >= WD_MAX);
      if (!finished) begin
         finished = 1'b1;
         checks++; errs++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_MAX);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule